// File: doc/BRIEF.md
# YUV to RGB Color Converter

This block turns a stream of 8-bit luma/chroma triples into 8-bit red, green and blue samples with a programmable 3x4 affine matrix. Each matrix row holds three signed multipliers, applied to luma and the two chroma samples, and one signed additive constant. The affine sum is kept at full precision, rounded to the nearest integer and clamped to the 8-bit range. Twelve coefficient registers are loaded through a simple indexed write port. After reset they hold a BT.601 studio-range conversion.

Each pixel carries two per-pixel controls. The bypass flag sends an RGB pixel straight through unchanged. The chroma-swap flag exchanges the two chroma samples before the matrix, for planar sources that store V ahead of U. Both paths share one fixed three-cycle pipeline, so pixel order is kept when bypass and conversion pixels are mixed in a stream.

Top module: `csc_yuv2rgb`

## Requirements
- R1: While reset is asserted, and after it, `out_valid` is 0 and the colour outputs are 0. After reset the coefficients hold the BT.601 set: luma 16 with both chroma 128 gives (0,0,0), and luma 235 with both chroma 128 gives (255,255,255).
- R2: Coefficient index k = 4*row + column. Row 0 drives green, row 1 red and row 2 blue. Columns 0, 1 and 2 multiply luma (`pix_c0`), first chroma (`pix_c1`) and second chroma (`pix_c2`). Column 3 is the additive constant.
- R3: A multiplier is the low 13 bits of `cfg_data`, read as signed with 10 fractional bits; the unused top bit is ignored. A constant is all 14 bits of `cfg_data`, read as signed with 4 fractional bits, and is aligned to 10 fractional bits before the sum.
- R4: Each output is floor((sum + 512) / 1024) of the full-precision sum at 10 fractional bits, clamped so that negatives give 0 and values above 255 give 255.
- R5: With `pix_bypass` high, `out_r`, `out_g` and `out_b` equal `pix_c0`, `pix_c1` and `pix_c2` unchanged, and `pix_swap_uv` has no effect.
- R6: With `pix_swap_uv` high and bypass low, `pix_c2` is used as the first chroma and `pix_c1` as the second.
- R7: `out_valid` and the result of an accepted pixel appear exactly 3 clock edges after the edge that samples `pix_valid_in` high, on both paths, in input order.
- R8: While `out_valid` is low, the colour outputs keep their last values.
- R9: A write with `cfg_idx` of 12 to 15 changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 4 | Coefficient index, 4*row + column |
| cfg_data | input | max(MUL_W,OFF_W) = 14 | Coefficient value |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_bypass | input | 1 | Pass the pixel through unconverted |
| pix_swap_uv | input | 1 | Exchange the chroma samples before conversion |
| pix_c0 | input | PIX_W = 8 | Luma, or red in bypass |
| pix_c1 | input | PIX_W = 8 | First chroma, or green in bypass |
| pix_c2 | input | PIX_W = 8 | Second chroma, or blue in bypass |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W = 8 | Red |
| out_g | output | PIX_W = 8 | Green |
| out_b | output | PIX_W = 8 | Blue |

## Verification
An input sampled at a rising edge reaches the outputs after the third rising edge. A coefficient write takes effect at its own edge. The bench drives every input at the falling edge and pushes each pixel's arithmetically computed result into a three-deep expected pipeline. Half a cycle after the next rising edge it compares the outputs with the entry pushed two steps earlier, which is the pixel that has now crossed three edges. Idle slots check that the last result is held. Coefficient changes are always separated from dependent pixels by idle cycles.

// File: rtl/csc_pkg.sv
package csc_pkg;
   localparam int NUM_ROWS    = 3;
   localparam int NUM_TERMS   = 4;
   localparam int NUM_COEF    = NUM_ROWS * NUM_TERMS;
   localparam int COEF_IDX_W  = 4;
   localparam int ROW_G       = 0;
   localparam int ROW_R       = 1;
   localparam int ROW_B       = 2;
   localparam int DFLT_MFRAC  = 10;
   localparam int DFLT_OFRAC  = 4;

   // Studio-range BT.601 set, as signed integers in the default formats
   // (multipliers with 10 fraction bits, constants with 4 fraction bits).
   function automatic int dflt_coef(int idx);
      case (idx)
         0:  return 1191;   1: return -401;  2: return -833;  3: return 2167;
         4:  return 1191;   5: return 0;     6: return 1634;  7: return -3567;
         8:  return 1191;   9: return 2066; 10: return 0;    11: return -4431;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank #(
   parameter int MUL_W    = 13,
   parameter int MUL_FRAC = 10,
   parameter int OFF_W    = 14,
   parameter int OFF_FRAC = 4,
   parameter int CFG_W    = 14
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cfg_we,
   input  logic [csc_pkg::COEF_IDX_W-1:0]         cfg_idx,
   input  logic [CFG_W-1:0]                       cfg_data,
   output logic signed [MUL_W-1:0]                mul_q [csc_pkg::NUM_ROWS*3],
   output logic signed [OFF_W-1:0]                off_q [csc_pkg::NUM_ROWS]
);
   localparam int NR     = csc_pkg::NUM_ROWS;
   localparam int NT     = csc_pkg::NUM_TERMS;
   localparam int IDX_W  = csc_pkg::COEF_IDX_W;
   localparam int MSCALE = 1 << (MUL_FRAC - csc_pkg::DFLT_MFRAC);
   localparam int OSCALE = 1 << (OFF_FRAC - csc_pkg::DFLT_OFRAC);

   for (genvar r = 0; r < NR; r++) begin : g_row
      for (genvar c = 0; c < NT - 1; c++) begin : g_mul
         localparam int IDX = r * NT + c;
         localparam logic [MUL_W-1:0] RST = MUL_W'(csc_pkg::dflt_coef(IDX) * MSCALE);
         logic [MUL_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RST;
            else if (cfg_we && cfg_idx == IDX_W'(IDX))
               q <= cfg_data[MUL_W-1:0];
         end
         assign mul_q[r*3+c] = $signed(q);
      end
      localparam int OIDX = r * NT + NT - 1;
      localparam logic [OFF_W-1:0] ORST = OFF_W'(csc_pkg::dflt_coef(OIDX) * OSCALE);
      logic [OFF_W-1:0] oq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            oq <= ORST;
         else if (cfg_we && cfg_idx == IDX_W'(OIDX))
            oq <= cfg_data[OFF_W-1:0];
      end
      assign off_q[r] = $signed(oq);
   end
endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac #(
   parameter int PIX_W = 8,
   parameter int MUL_W = 13,
   parameter int OFF_W = 14,
   parameter int SHIFT = 6,
   parameter int ACC_W = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [PIX_W-1:0]         y,
   input  logic [PIX_W-1:0]         u,
   input  logic [PIX_W-1:0]         v,
   input  logic signed [MUL_W-1:0]  ky,
   input  logic signed [MUL_W-1:0]  ku,
   input  logic signed [MUL_W-1:0]  kv,
   input  logic signed [OFF_W-1:0]  koff,
   output logic signed [ACC_W-1:0]  acc_q
);
   logic signed [ACC_W-1:0] ey, eu, ev;
   logic signed [ACC_W-1:0] cy, cu, cv, co;
   logic signed [ACC_W-1:0] sum;

   always_comb begin
      ey  = ACC_W'($signed({1'b0, y}));
      eu  = ACC_W'($signed({1'b0, u}));
      ev  = ACC_W'($signed({1'b0, v}));
      cy  = ACC_W'(ky);
      cu  = ACC_W'(ku);
      cv  = ACC_W'(kv);
      co  = ACC_W'(koff) <<< SHIFT;
      sum = ey * cy + eu * cu + ev * cv + co;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (en)
         acc_q <= sum;
   end
endmodule

// File: rtl/csc_round_clamp.sv
module csc_round_clamp #(
   parameter int ACC_W = 24,
   parameter int FRAC  = 10,
   parameter int PIX_W = 8
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic [PIX_W-1:0]        pix
);
   localparam int INT_W = ACC_W - FRAC;
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'd1 << (FRAC - 1));
   localparam logic signed [INT_W-1:0] TOP  = INT_W'((64'd1 << PIX_W) - 1);

   logic signed [ACC_W-1:0] biased;
   logic signed [INT_W-1:0] whole;
   logic                    unused_frac;

   always_comb begin
      biased = acc + HALF;
      whole  = biased[ACC_W-1:FRAC];
      if (whole[INT_W-1])
         pix = '0;
      else if (whole > TOP)
         pix = '1;
      else
         pix = whole[PIX_W-1:0];
   end
   assign unused_frac = ^biased[FRAC-1:0];
endmodule

// File: rtl/csc_yuv2rgb.sv
module csc_yuv2rgb #(
   parameter int PIX_W    = 8,
   parameter int MUL_W    = 13,
   parameter int MUL_FRAC = 10,
   parameter int OFF_W    = 14,
   parameter int OFF_FRAC = 4
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          cfg_we,
   input  logic [csc_pkg::COEF_IDX_W-1:0]                cfg_idx,
   input  logic [((OFF_W > MUL_W) ? OFF_W : MUL_W)-1:0]  cfg_data,
   input  logic                                          pix_valid_in,
   input  logic                                          pix_bypass,
   input  logic                                          pix_swap_uv,
   input  logic [PIX_W-1:0]                              pix_c0,
   input  logic [PIX_W-1:0]                              pix_c1,
   input  logic [PIX_W-1:0]                              pix_c2,
   output logic                                          out_valid,
   output logic [PIX_W-1:0]                              out_r,
   output logic [PIX_W-1:0]                              out_g,
   output logic [PIX_W-1:0]                              out_b
);
   localparam int NR     = csc_pkg::NUM_ROWS;
   localparam int CFG_W  = (OFF_W > MUL_W) ? OFF_W : MUL_W;
   localparam int SHIFT  = MUL_FRAC - OFF_FRAC;
   localparam int PROD_W = PIX_W + 1 + MUL_W;
   localparam int OFFA_W = OFF_W + SHIFT;
   localparam int ACC_W  = ((PROD_W > OFFA_W) ? PROD_W : OFFA_W) + 2;

   // elaboration-time parameter checks
   if (MUL_FRAC < csc_pkg::DFLT_MFRAC || OFF_FRAC < csc_pkg::DFLT_OFRAC) begin : g_bad_frac
      $error("fraction widths below the default coefficient formats");
   end
   if (OFF_FRAC > MUL_FRAC) begin : g_bad_align
      $error("constant fraction must not exceed multiplier fraction");
   end
   if (MUL_W <= MUL_FRAC || OFF_W <= OFF_FRAC || PIX_W < 2) begin : g_bad_width
      $error("coefficient or pixel width too small");
   end

   logic signed [MUL_W-1:0] mul_q [NR*3];
   logic signed [OFF_W-1:0] off_q [NR];

   csc_coef_bank #(
      .MUL_W(MUL_W), .MUL_FRAC(MUL_FRAC), .OFF_W(OFF_W),
      .OFF_FRAC(OFF_FRAC), .CFG_W(CFG_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .mul_q(mul_q), .off_q(off_q)
   );

   // stage 1: capture and chroma ordering
   logic             s1_vld, s1_byp;
   logic [PIX_W-1:0] s1_a, s1_b, s1_c;
   logic             do_swap;
   assign do_swap = pix_swap_uv && !pix_bypass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_byp <= 1'b0;
         s1_a   <= '0;
         s1_b   <= '0;
         s1_c   <= '0;
      end else begin
         s1_vld <= pix_valid_in;
         if (pix_valid_in) begin
            s1_byp <= pix_bypass;
            s1_a   <= pix_c0;
            s1_b   <= do_swap ? pix_c2 : pix_c1;
            s1_c   <= do_swap ? pix_c1 : pix_c2;
         end
      end
   end

   // stage 2: per-row affine sums, pass-through copy alongside
   logic signed [ACC_W-1:0] acc [NR];
   logic [PIX_W-1:0]        conv [NR];

   for (genvar r = 0; r < NR; r++) begin : g_row
      csc_row_mac #(
         .PIX_W(PIX_W), .MUL_W(MUL_W), .OFF_W(OFF_W),
         .SHIFT(SHIFT), .ACC_W(ACC_W)
      ) u_mac (
         .clk(clk), .rst_n(rst_n), .en(s1_vld),
         .y(s1_a), .u(s1_b), .v(s1_c),
         .ky(mul_q[r*3]), .ku(mul_q[r*3+1]), .kv(mul_q[r*3+2]),
         .koff(off_q[r]), .acc_q(acc[r])
      );
      csc_round_clamp #(
         .ACC_W(ACC_W), .FRAC(MUL_FRAC), .PIX_W(PIX_W)
      ) u_clamp (
         .acc(acc[r]), .pix(conv[r])
      );
   end

   logic             s2_vld, s2_byp;
   logic [PIX_W-1:0] s2_a, s2_b, s2_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld <= 1'b0;
         s2_byp <= 1'b0;
         s2_a   <= '0;
         s2_b   <= '0;
         s2_c   <= '0;
      end else begin
         s2_vld <= s1_vld;
         if (s1_vld) begin
            s2_byp <= s1_byp;
            s2_a   <= s1_a;
            s2_b   <= s1_b;
            s2_c   <= s1_c;
         end
      end
   end

   // stage 3: round, clamp, select and hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_r     <= '0;
         out_g     <= '0;
         out_b     <= '0;
      end else begin
         out_valid <= s2_vld;
         if (s2_vld) begin
            out_r <= s2_byp ? s2_a : conv[csc_pkg::ROW_R];
            out_g <= s2_byp ? s2_b : conv[csc_pkg::ROW_G];
            out_b <= s2_byp ? s2_c : conv[csc_pkg::ROW_B];
         end
      end
   end
endmodule

// File: rtl/csc_yuv2rgb_chk.sv
module csc_yuv2rgb_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_valid_in,
   input logic             pix_bypass,
   input logic [PIX_W-1:0] pix_c0,
   input logic [PIX_W-1:0] pix_c1,
   input logic [PIX_W-1:0] pix_c2,
   input logic             out_valid,
   input logic [PIX_W-1:0] out_r,
   input logic [PIX_W-1:0] out_g,
   input logic [PIX_W-1:0] out_b
);
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cyc <= 2'd0;
      else if (cyc != 2'd3)
         cyc <= cyc + 2'd1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3) |-> out_valid == $past(pix_valid_in, 3)); // R7

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && $past(pix_valid_in && pix_bypass, 3)) |->
      (out_r == $past(pix_c0, 3) && out_g == $past(pix_c1, 3) && out_b == $past(pix_c2, 3))); // R5

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0 && !out_valid) |-> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R8
endmodule

bind csc_yuv2rgb csc_yuv2rgb_chk #(.PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid_in(pix_valid_in), .pix_bypass(pix_bypass),
   .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2), .out_valid(out_valid),
   .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/tb_csc_yuv2rgb.sv
`timescale 1ns/1ps
module tb_csc_yuv2rgb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [13:0] cfg_data = '0;
   logic        pix_valid_in = 1'b0, pix_bypass = 1'b0, pix_swap_uv = 1'b0;
   logic [7:0]  pix_c0 = '0, pix_c1 = '0, pix_c2 = '0;
   logic        out_valid;
   logic [7:0]  out_r, out_g, out_b;

   csc_yuv2rgb dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .pix_valid_in(pix_valid_in), .pix_bypass(pix_bypass), .pix_swap_uv(pix_swap_uv),
      .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   always #4 clk = ~clk;

   int tests = 0, fails = 0;
   int bm [12];
   bit pv [3];
   int pr [3], pg [3], pb [3];
   string ptag [3];
   int lr = 0, lg = 0, lb = 0;
   int lfsr = 32'h1ACE;

   function automatic int sx(int raw, int w);
      int m = raw & ((1 << w) - 1);
      if (m >= (1 << (w - 1))) m = m - (1 << w);
      return m;
   endfunction

   function automatic int conv(int row, int y, int u, int v);
      int acc = bm[row*4]*y + bm[row*4+1]*u + bm[row*4+2]*v + bm[row*4+3]*64;
      int q = (acc + 512) >>> 10;
      if (q < 0) q = 0;
      if (q > 255) q = 255;
      return q;
   endfunction

   task automatic load_defaults();
      bm = '{1191, -401, -833, 2167, 1191, 0, 1634, -3567, 1191, 2066, 0, -4431};
   endtask

   task automatic chk(bit ok, string tag, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step(bit v, bit byp, bit sw, int a, int b, int c, string tag);
      int u, w;
      pix_valid_in = v; pix_bypass = byp; pix_swap_uv = sw;
      pix_c0 = a[7:0]; pix_c1 = b[7:0]; pix_c2 = c[7:0];
      for (int i = 2; i > 0; i--) begin
         pv[i] = pv[i-1]; pr[i] = pr[i-1]; pg[i] = pg[i-1]; pb[i] = pb[i-1]; ptag[i] = ptag[i-1];
      end
      pv[0] = v; ptag[0] = tag;
      if (byp) begin
         pr[0] = a; pg[0] = b; pb[0] = c;
      end else begin
         u = sw ? c : b;
         w = sw ? b : c;
         pr[0] = conv(1, a, u, w); pg[0] = conv(0, a, u, w); pb[0] = conv(2, a, u, w);
      end
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      if (pv[2]) begin
         lr = pr[2]; lg = pg[2]; lb = pb[2];
         chk(out_valid && out_r == pr[2][7:0] && out_g == pg[2][7:0] && out_b == pb[2][7:0],
             {ptag[2], " R7 data"}, {out_valid, out_r, out_g, out_b}, {1'b1, pr[2][7:0], pg[2][7:0], pb[2][7:0]});
      end else begin
         chk(!out_valid && out_r == lr[7:0] && out_g == lg[7:0] && out_b == lb[7:0],
             "R8 idle hold", {out_valid, out_r, out_g, out_b}, {1'b0, lr[7:0], lg[7:0], lb[7:0]});
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "idle");
   endtask

   task automatic wr(int idx, int data);
      cfg_we = 1'b1; cfg_idx = idx[3:0]; cfg_data = data[13:0];
      if (idx < 12) bm[idx] = sx(data, (idx % 4 == 3) ? 14 : 13);
      step(0, 0, 0, 0, 0, 0, "cfg");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      pix_valid_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(!out_valid && out_r == 0 && out_g == 0 && out_b == 0, "R1 in reset",
          {out_valid, out_r, out_g, out_b}, 0);
      rst_n = 1'b1;
      load_defaults();
      for (int i = 0; i < 3; i++) pv[i] = 0;
      lr = 0; lg = 0; lb = 0;
   endtask

   function automatic int nextrnd();
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      return lfsr & 16'hFFFF;
   endfunction

   initial begin
      repeat (199000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset();
      idle(2);
      // R1: BT.601 black and white
      step(1, 0, 0, 16, 128, 128, "R1 black");
      idle(2);
      chk({out_r, out_g, out_b} == 24'h000000, "R1 black lit", {out_r, out_g, out_b}, 0);
      step(1, 0, 0, 235, 128, 128, "R1 white");
      idle(2);
      chk({out_r, out_g, out_b} == 24'hFFFFFF, "R1 white lit", {out_r, out_g, out_b}, 24'hFFFFFF);
      // R2 R4: default-matrix sweep, back to back
      for (int y = 0; y < 256; y += 5)
         for (int u = 0; u < 256; u += 15)
            for (int v = 0; v < 256; v += 15)
               step(1, 0, 0, y, u, v, "R2 sweep");
      idle(3);
      // R6: chroma swap sweep
      for (int y = 0; y < 256; y += 15)
         for (int u = 0; u < 256; u += 15)
            for (int v = 0; v < 256; v += 15)
               step(1, 0, 1, y, u, v, "R6 swap");
      idle(3);
      // R5: bypass, swap ignored
      for (int y = 0; y < 256; y += 15)
         for (int u = 0; u < 256; u += 15)
            for (int v = 0; v < 256; v += 15)
               step(1, 1, (y + v) % 2 == 1, y, u, v, "R5 bypass");
      idle(3);
      // R7: mixed stream with gaps and path changes
      for (int i = 0; i < 3000; i++) begin
         int r = nextrnd();
         step((r & 3) != 0, r[2], r[3], (r >> 4) & 255, (r >> 8) & 255, nextrnd() & 255, "R7 mix");
      end
      idle(3);
      // R9: writes to unused indices
      for (int k = 12; k < 16; k++) wr(k, 14'h1555);
      idle(3);
      for (int y = 0; y < 256; y += 17) step(1, 0, 0, y, 90, 200, "R9 unused idx");
      step(1, 0, 0, 235, 128, 128, "R9 white");
      idle(2);
      chk({out_r, out_g, out_b} == 24'hFFFFFF, "R9 white lit", {out_r, out_g, out_b}, 24'hFFFFFF);
      // R4: rounding at exact halves (green row, multiplier 0.5)
      wr(0, 14'h0200); wr(1, 0); wr(2, 0); wr(3, 0);
      idle(3);
      step(1, 0, 0, 1, 0, 0, "R4 half up");
      idle(2);
      chk(out_g == 8'd1, "R4 0.5 -> 1", out_g, 1);
      step(1, 0, 0, 3, 0, 0, "R4 1.5");
      idle(2);
      chk(out_g == 8'd2, "R4 1.5 -> 2", out_g, 2);
      // R3: constants with 4 fraction bits, -0.5 and +0.5
      wr(0, 0); wr(3, 14'h3FF8);
      idle(3);
      step(1, 0, 0, 200, 200, 200, "R3 const -0.5");
      idle(2);
      chk(out_g == 8'd0, "R3 -0.5 -> 0", out_g, 0);
      wr(3, 14'h0008);
      idle(3);
      step(1, 0, 0, 7, 7, 7, "R3 const +0.5");
      idle(2);
      chk(out_g == 8'd1, "R3 +0.5 -> 1", out_g, 1);
      // R3: multiplier top cfg bit ignored; R2 column mapping on red row
      wr(4, 14'h2400); wr(5, 0); wr(6, 0); wr(7, 0);
      idle(3);
      step(1, 0, 0, 77, 3, 9, "R3 mul width");
      idle(2);
      chk(out_r == 8'd77, "R3 red = luma", out_r, 77);
      wr(4, 0); wr(6, 14'h0400);
      idle(3);
      step(1, 0, 0, 11, 22, 133, "R2 red col2");
      idle(2);
      chk(out_r == 8'd133, "R2 red = second chroma", out_r, 133);
      // R4: clamp high on red, low on blue
      wr(4, 14'h0FFF); wr(7, 14'h1FFF);
      wr(8, 14'h1000); wr(9, 0); wr(10, 0); wr(11, 14'h2000);
      idle(3);
      for (int y = 0; y < 256; y += 3) step(1, 0, 0, y, y ^ 8'h5A, 255 - y, "R4 clamp");
      idle(2);
      chk(out_r == 8'd255 && out_b == 8'd0, "R4 clamp lit", {out_r, out_b}, 16'hFF00);
      // R1: reset restores defaults
      do_reset();
      idle(2);
      step(1, 0, 0, 235, 128, 128, "R1 defaults back");
      idle(2);
      chk({out_r, out_g, out_b} == 24'hFFFFFF, "R1 white after reset", {out_r, out_g, out_b}, 24'hFFFFFF);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule